// File: doc/BRIEF.md
# Add Result Status Flag Generator

This block adds two operands at one of two widths and produces the arithmetic status flags that describe the result. A width select picks byte mode or word mode. In byte mode only the low bytes of the operands take part. The sum is combinational. The six status flags are carry, parity, auxiliary carry, zero, sign and overflow. They are captured in a register on the rising clock edge, but only in cycles where the update enable is high. In all other cycles the register keeps its previous value.

The block is meant to sit behind an instruction decoder. The decoder raises the update enable for instructions that write the flags and leaves it low for instructions that must preserve them. Three control flag bits (single-step, interrupt enable, string direction) are owned elsewhere. They pass through this block unchanged, so that the whole flag word can be assembled next to the status bits.

The flag register has no internal sequencing: each edge either loads or holds. Two conditions name its behaviour:
- **RESET**: all flags are clear.
- **RUN**: on each rising edge the register goes through either **LOAD** (the enable is high) or **HOLD** (the enable is low).

The only transition is RESET to RUN, taken on the first edge after the active-low reset is released.

Top module: `ars_top`

## Requirements
- R1: In word mode (`wide`=1) `sum` equals `opa`+`opb` modulo 2^16. In byte mode (`wide`=0) `sum[7:0]` equals `opa[7:0]`+`opb[7:0]` modulo 2^8 and `sum[15:8]` is zero.
- R2: Carry is the carry out of bit 15 in word mode and out of bit 7 in byte mode.
- R3: Parity is 1 when `sum[7:0]` holds an even number of one bits, in both modes.
- R4: Auxiliary carry is the carry from bit 3 into bit 4, that is bit 4 of `opa[3:0]`+`opb[3:0]`, in both modes.
- R5: Zero is 1 when the result at the selected width is all zeros.
- R6: Sign is bit 15 of `sum` in word mode and bit 7 in byte mode.
- R7: Overflow is 1 when both operands have the same sign bit at the selected width and the result's sign bit differs from it.
- R8: The flag outputs take the values from R2 to R7 on the rising edge where `upd_en`=1. On an edge where `upd_en`=0 they keep their previous values.
- R9: While `rst_n` is low all six flag outputs are 0.
- R10: `ctl_out` equals `ctl_in` at all times.
- R11: In byte mode the upper operand bytes `opa[15:8]` and `opb[15:8]` have no effect on `sum` or on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| wide | input | 1 | 1 selects word mode, 0 selects byte mode |
| upd_en | input | 1 | Load the flag register on this edge |
| ctl_in | input | 3 | Control flags passed through |
| sum | output | 16 | Combinational sum |
| carry_f | output | 1 | Registered carry flag |
| parity_f | output | 1 | Registered parity flag |
| aux_f | output | 1 | Registered auxiliary carry flag |
| zero_f | output | 1 | Registered zero flag |
| sign_f | output | 1 | Registered sign flag |
| ovf_f | output | 1 | Registered overflow flag |
| ctl_out | output | 3 | Control flags, equal to `ctl_in` |

## Verification
The clocked properties assume that `opa`, `opb`, `wide` and `upd_en` are stable across each rising edge. Under that assumption the value of `sum` sampled before the edge is the value the flag register loaded. The stimulus meets this by changing every input only on the falling edge. The stimulus covers both widths, junk in the upper operand bytes during byte mode, enable-low cycles between loads, and the carry and overflow boundaries at both widths.

// File: rtl/ars_pkg.sv
package ars_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NIB_W  = 4;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } ars_flags_t;
endpackage

// File: rtl/ars_adder.sv
module ars_adder
    import ars_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         wide,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         c_aux,
    output logic         ovf
);
    localparam int unsigned HI_W = W - BYTE_W;

    logic [W:0]        full_s;
    logic [BYTE_W:0]   byte_s;
    logic [NIB_W:0]    nib_s;
    logic              sa, sb, sr;

    always_comb begin
        full_s = {1'b0, opa} + {1'b0, opb};
        byte_s = {1'b0, opa[BYTE_W-1:0]} + {1'b0, opb[BYTE_W-1:0]};
        nib_s  = {1'b0, opa[NIB_W-1:0]} + {1'b0, opb[NIB_W-1:0]};
        c_aux  = nib_s[NIB_W];
        if (wide) begin
            sum   = full_s[W-1:0];
            c_out = full_s[W];
            sa    = opa[W-1];
            sb    = opb[W-1];
            sr    = full_s[W-1];
        end else begin
            sum   = {{HI_W{1'b0}}, byte_s[BYTE_W-1:0]};
            c_out = byte_s[BYTE_W];
            sa    = opa[BYTE_W-1];
            sb    = opb[BYTE_W-1];
            sr    = byte_s[BYTE_W-1];
        end
        ovf = (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/ars_flaggen.sv
module ars_flaggen
    import ars_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] sum,
    input  logic         wide,
    input  logic         c_out,
    input  logic         c_aux,
    input  logic         ovf,
    output ars_flags_t   flags
);
    always_comb begin
        flags.cf = c_out;
        flags.pf = ~^sum[BYTE_W-1:0];
        flags.af = c_aux;
        flags.zf = wide ? (sum == '0) : (sum[BYTE_W-1:0] == '0);
        flags.sf = wide ? sum[W-1] : sum[BYTE_W-1];
        flags.of = ovf;
    end
endmodule

// File: rtl/ars_top.sv
module ars_top
    import ars_pkg::*;
#(
    parameter int unsigned W     = 16,
    parameter int unsigned CTL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic             wide,
    input  logic             upd_en,
    input  logic [CTL_W-1:0] ctl_in,
    output logic [W-1:0]     sum,
    output logic             carry_f,
    output logic             parity_f,
    output logic             aux_f,
    output logic             zero_f,
    output logic             sign_f,
    output logic             ovf_f,
    output logic [CTL_W-1:0] ctl_out
);
    logic       c_out, c_aux, ovf;
    ars_flags_t nxt_flags;
    ars_flags_t flag_q;

    ars_adder #(.W(W)) u_add (
        .opa(opa), .opb(opb), .wide(wide),
        .sum(sum), .c_out(c_out), .c_aux(c_aux), .ovf(ovf)
    );

    ars_flaggen #(.W(W)) u_flg (
        .sum(sum), .wide(wide), .c_out(c_out), .c_aux(c_aux), .ovf(ovf),
        .flags(nxt_flags)
    );

    // RESET clears the register; in RUN each edge is LOAD or HOLD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= '0;
        else if (upd_en)
            flag_q <= nxt_flags;
    end

    always_comb begin
        carry_f  = flag_q.cf;
        parity_f = flag_q.pf;
        aux_f    = flag_q.af;
        zero_f   = flag_q.zf;
        sign_f   = flag_q.sf;
        ovf_f    = flag_q.of;
        ctl_out  = ctl_in;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable({carry_f, parity_f, aux_f, zero_f, sign_f, ovf_f}));

    p_byte_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (sum[W-1:BYTE_W] == '0));

    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> zero_f == ($past(wide) ? ($past(sum) == '0)
                                          : ($past(sum[BYTE_W-1:0]) == '0)));

    p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> sign_f == ($past(wide) ? $past(sum[W-1]) : $past(sum[BYTE_W-1])));

    p_ovf_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !wide && (opa[BYTE_W-1] == opb[BYTE_W-1]))
        |=> ovf_f == ($past(opa[BYTE_W-1]) != $past(sum[BYTE_W-1])));

    p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && wide && opa[W-1] && opb[W-1]) |=> carry_f);
endmodule

// File: tb/sim_ars_top.sv
module sim_ars_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opa = '0, opb = '0;
    logic        wide = 1'b0, upd_en = 1'b0;
    logic [2:0]  ctl_in = '0;
    logic [15:0] sum;
    logic        carry_f, parity_f, aux_f, zero_f, sign_f, ovf_f;
    logic [2:0]  ctl_out;

    int vectors = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] s;
        logic [5:0]  f;   // cf pf af zf sf of
        logic [2:0]  c;
        bit          en;
        bit          junk;
    } exp_t;

    exp_t q[$];
    logic [5:0] held = '0;

    always #5 clk = ~clk;

    ars_top u0 (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .wide(wide),
        .upd_en(upd_en), .ctl_in(ctl_in), .sum(sum),
        .carry_f(carry_f), .parity_f(parity_f), .aux_f(aux_f),
        .zero_f(zero_f), .sign_f(sign_f), .ovf_f(ovf_f), .ctl_out(ctl_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic w, input logic en, input logic [2:0] c);
        exp_t e;
        logic [16:0] s17;
        logic [8:0]  s9;
        logic [4:0]  n5;
        logic [15:0] r;
        logic cf, am, bm, rm;
        @(negedge clk);
        opa = a; opb = b; wide = w; upd_en = en; ctl_in = c;
        n5 = {1'b0, a[3:0]} + {1'b0, b[3:0]};
        if (w) begin
            s17 = {1'b0, a} + {1'b0, b};
            r = s17[15:0]; cf = s17[16];
            am = a[15]; bm = b[15]; rm = r[15];
        end else begin
            s9 = {1'b0, a[7:0]} + {1'b0, b[7:0]};
            r = {8'h00, s9[7:0]}; cf = s9[8];
            am = a[7]; bm = b[7]; rm = r[7];
        end
        if (en)
            held = {cf, ~^r[7:0], n5[4], (r == 16'h0), rm, (am == bm) && (rm != am)};
        e.s = r; e.f = held; e.c = c; e.en = en;
        e.junk = !w && ((a[15:8] != 0) || (b[15:8] != 0));
        q.push_back(e);
    endtask

    // monitor: pops one expected item per edge after the driver pushed it
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            logic [5:0] f;
            e = q.pop_front();
            f = {carry_f, parity_f, aux_f, zero_f, sign_f, ovf_f};
            chk("R1 sum", sum, e.s);
            if (!e.en)
                chk("R8 hold", {10'h0, f}, {10'h0, e.f});
            else begin
                chk("R2 carry",  {15'h0, f[5]}, {15'h0, e.f[5]});
                chk("R3 parity", {15'h0, f[4]}, {15'h0, e.f[4]});
                chk("R4 aux",    {15'h0, f[3]}, {15'h0, e.f[3]});
                chk("R5 zero",   {15'h0, f[2]}, {15'h0, e.f[2]});
                chk("R6 sign",   {15'h0, f[1]}, {15'h0, e.f[1]});
                chk("R7 ovf",    {15'h0, f[0]}, {15'h0, e.f[0]});
            end
            chk("R10 ctl", {13'h0, ctl_out}, {13'h0, e.c});
            if (e.junk)
                chk("R11 upper bytes ignored", {sum[15:0] ^ e.s, 10'h0, f ^ e.f} == 32'h0 ? 16'h0 : 16'h1, 16'h0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset flags", {10'h0, carry_f, parity_f, aux_f, zero_f, sign_f, ovf_f}, 16'h0);
        rst_n = 1'b1;
        drive(16'h009C, 16'h0064, 1'b0, 1'b1, 3'b101); // 00, CF PF AF ZF
        drive(16'h34F5, 16'h95EB, 1'b1, 1'b1, 3'b010); // CAE0, AF SF
        drive(16'h1111, 16'h2222, 1'b1, 1'b0, 3'b000); // R8 hold
        drive(16'h0000, 16'h0000, 1'b1, 1'b0, 3'b111); // R8 hold on zero
        drive(16'h0038, 16'h002F, 1'b0, 1'b1, 3'b001); // 67
        drive(16'h007F, 16'h0001, 1'b0, 1'b1, 3'b000); // R7 byte overflow
        drive(16'h0080, 16'h0080, 1'b0, 1'b1, 3'b000); // carry+ovf byte
        drive(16'h7FFF, 16'h0001, 1'b1, 1'b1, 3'b000); // R7 word overflow
        drive(16'h8000, 16'h8000, 1'b1, 1'b1, 3'b000); // R2 word carry, zero
        drive(16'hFF00, 16'h0100, 1'b1, 1'b1, 3'b000); // R5 word zero, low byte zero
        drive(16'h0100, 16'h0000, 1'b1, 1'b1, 3'b000); // R5 word nonzero, low byte zero
        drive(16'hAB9C, 16'hCD64, 1'b0, 1'b1, 3'b100); // R11 junk upper bytes
        drive(16'h12FF, 16'h3401, 1'b0, 1'b1, 3'b000); // R11 byte carry, junk
        drive(16'h00F0, 16'h00F0, 1'b0, 1'b0, 3'b011); // R8 hold
        for (int i = 0; i < 60; i++)
            drive(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end
endmodule